// File: doc/BRIEF.md
# Peripheral Access Firewall Controller

This block sits beside a bus fabric and decides, for each access a requester makes, whether that requester may reach a given target peripheral. A requester is described by a 3-bit compartment identifier, a secure flag and a privileged flag. For every peripheral the block keeps a secure-only bit, a privileged-only bit, a lock bit, a compartment filtering word and a hardware semaphore. Software programs all of them through a simple 32-bit register port. The fabric presents a peripheral index together with the requester attributes, and it receives an allow or deny verdict one clock later.

Attribute filtering comes first. A secure-only peripheral rejects non-secure requesters, and a privileged-only peripheral rejects unprivileged ones. Compartment filtering, when it is switched on, then admits a single static compartment. In semaphore mode it instead admits whichever compartment from an allow list currently holds the peripheral's semaphore. Per-peripheral lock bits and a global lock freeze the configuration. Semaphores keep working under either lock, so ownership can still be handed over at run time.

Top module: `periph_firewall`

## Requirements
- R1: After reset every bitmap, compartment word, semaphore and the global lock read 0, and an in-range peripheral allows any requester.
- R2: Peripheral id's secure-only bit sits at byte offset 0x10 + 4*(id/32), bit id%32. Its privileged-only bit sits at 0x30 + 4*(id/32), bit id%32. Both bits read back as written.
- R3: A requester with the secure flag low is denied at a secure-only peripheral. A requester with the privileged flag low is denied at a privileged-only peripheral.
- R4: The compartment word of peripheral id sits at 0x100 + 8*id. Its fields are: bit 0 filter enable, bit 1 semaphore mode, bits 6:4 static compartment, bits 23:16 allow list (bit n admits compartment n). All other bits read 0. With the filter off, a requester that passes R3 is allowed. With the filter on and semaphore mode off, the requester's compartment must equal the static compartment.
- R5: With the filter and semaphore mode both on, a requester is allowed only if its compartment is on the allow list and currently holds that peripheral's semaphore.
- R6: The semaphore of peripheral id sits at 0x104 + 8*id. It reads bit 0 = held and bits 6:4 = owner. A write with data bit 0 = 1 is a take. A take succeeds only if the semaphore is free, semaphore mode is on and the writer compartment (cfg_wcid) is on the allow list. A successful take records the writer as owner. A failed take changes nothing.
- R7: A write with data bit 0 = 0 is a release. It clears the semaphore (held and owner both become 0) only when the semaphore is held by the writer compartment. Otherwise the write is ignored.
- R8: The lock bitmap sits at 0x50 + 4*(id/32), bit id%32. Writing 1 sets a bit; writing 0 does not clear it, and only reset does. A locked peripheral ignores writes to its secure-only bit, its privileged-only bit and its compartment word.
- R9: Writing 1 to bit 0 at offset 0x0 sets the global lock. It then reads back 1 and cannot be cleared. Once it is set, all secure, privileged, lock and compartment writes are ignored, while semaphore takes and releases still operate.
- R10: A peripheral index at or above NUM_PERIPH is always denied. Writes to its bits or registers are ignored, and those locations read 0.
- R11: The verdict on chk_allow is registered. It reflects the check inputs and configuration present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Byte address for both write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_wcid | input | 3 | Compartment of the register writer, used by semaphore takes and releases |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| chk_idx | input | 7 | Peripheral index to check |
| chk_cid | input | 3 | Requester compartment |
| chk_sec | input | 1 | Requester secure flag |
| chk_priv | input | 1 | Requester privileged flag |
| chk_allow | output | 1 | Registered verdict, 1 = allow |

## Verification
The bench builds the block with NUM_PERIPH = 40. The lowest bitmap words are therefore full, the second word is only partly populated, and the two top words are absent. This puts the out-of-range and partial-word behaviour within reach of short sweeps. Each access sweep walks every index up to four past the last peripheral, against all eight compartments and all four secure and privilege combinations. The compartment patterns are chosen so that static mode, semaphore mode, filter off, allow-list hits and misses all occur. Read-back sweeps cover every register of the 40 peripherals and the vacant slots after them. These sweeps are repeated after per-peripheral locking and again after the global lock.

// File: rtl/pfw_pkg.sv
`timescale 1ns/1ps
package pfw_pkg;

   localparam int PFW_MAX_PERIPH  = 128;
   localparam int PFW_IDX_W       = 7;
   localparam int PFW_CID_W       = 3;
   localparam int PFW_NUM_CID     = 1 << PFW_CID_W;
   localparam int PFW_WORD_W      = 32;
   localparam int PFW_NUM_WORDS   = PFW_MAX_PERIPH / PFW_WORD_W;

   // byte offsets of the register groups
   localparam int PFW_OFF_CTRL    = 'h000;
   localparam int PFW_OFF_SEC     = 'h010;
   localparam int PFW_OFF_PRIV    = 'h030;
   localparam int PFW_OFF_LOCK    = 'h050;
   localparam int PFW_OFF_SLOT    = 'h100;
   localparam int PFW_SLOT_STRIDE = 8;
   localparam int PFW_OFF_SEM     = 4;

   typedef struct packed {
      logic [PFW_NUM_CID-1:0] allow_list;
      logic [PFW_CID_W-1:0]   static_cid;
      logic                   sem_mode;
      logic                   filt_en;
   } pfw_cid_cfg_t;

   typedef struct packed {
      logic [PFW_CID_W-1:0] owner;
      logic                 held;
   } pfw_sem_t;

   function automatic pfw_cid_cfg_t pfw_decode_cfg(input logic [31:0] w);
      pfw_cid_cfg_t c;
      c.filt_en    = w[0];
      c.sem_mode   = w[1];
      c.static_cid = w[6:4];
      c.allow_list = w[23:16];
      return c;
   endfunction

   function automatic logic [31:0] pfw_encode_cfg(input pfw_cid_cfg_t c);
      logic [31:0] w;
      w        = '0;
      w[0]     = c.filt_en;
      w[1]     = c.sem_mode;
      w[6:4]   = c.static_cid;
      w[23:16] = c.allow_list;
      return w;
   endfunction

   function automatic logic [31:0] pfw_encode_sem(input pfw_sem_t s);
      logic [31:0] w;
      w      = '0;
      w[0]   = s.held;
      w[6:4] = s.owner;
      return w;
   endfunction

endpackage

// File: rtl/pfw_bitmap_bank.sv
`timescale 1ns/1ps
// One packed attribute bitmap, 32 peripherals per word.
// SET_ONLY selects a write-one-to-set variant (lock bits) instead of plain storage.
module pfw_bitmap_bank
   import pfw_pkg::*;
#(
   parameter int NUM_PERIPH = 128,
   parameter int ADDR_W     = 12,
   parameter int BASE       = PFW_OFF_SEC,
   parameter bit SET_ONLY   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [31:0]           wr_data,
   input  logic [NUM_PERIPH-1:0] hold_mask,
   input  logic                  freeze,
   output logic [NUM_PERIPH-1:0] bits_o
);

   for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_bit
      localparam int WORD = gi / PFW_WORD_W;
      localparam int POS  = gi % PFW_WORD_W;
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(BASE + 4 * WORD);

      logic hit;
      logic bit_q;

      assign hit       = wr_en && (wr_addr == WADDR) && !freeze && !hold_mask[gi];
      assign bits_o[gi] = bit_q;

      if (SET_ONLY) begin : g_set_only
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    bit_q <= 1'b0;
            else if (hit && wr_data[POS])  bit_q <= 1'b1;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bit_q <= 1'b0;
            else if (hit) bit_q <= wr_data[POS];
         end
      end
   end

endmodule

// File: rtl/pfw_slot.sv
`timescale 1ns/1ps
// Compartment configuration word and hardware semaphore of one peripheral.
module pfw_slot
   import pfw_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int SLOT   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  pfw_cid_cfg_t         wr_cfg,
   input  logic                 wr_take,
   input  logic [PFW_CID_W-1:0] wr_cid,
   input  logic                 locked,
   input  logic                 freeze,
   output pfw_cid_cfg_t         cfg_o,
   output pfw_sem_t             sem_o
);

   localparam int CFG_OFF = PFW_OFF_SLOT + PFW_SLOT_STRIDE * SLOT;
   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_OFF);
   localparam logic [ADDR_W-1:0] SEM_ADDR = ADDR_W'(CFG_OFF + PFW_OFF_SEM);

   pfw_cid_cfg_t cfg_q;
   pfw_sem_t     sem_q;

   logic cfg_hit, sem_hit, take_ok, drop_ok;

   assign cfg_hit = wr_en && (wr_addr == CFG_ADDR) && !locked && !freeze;
   assign sem_hit = wr_en && (wr_addr == SEM_ADDR);
   assign take_ok = !sem_q.held && cfg_q.sem_mode && cfg_q.allow_list[wr_cid];
   assign drop_ok = sem_q.held && (sem_q.owner == wr_cid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (cfg_hit) cfg_q <= wr_cfg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sem_q <= '0;
      end else if (sem_hit) begin
         if (wr_take && take_ok) begin
            sem_q.held  <= 1'b1;
            sem_q.owner <= wr_cid;
         end else if (!wr_take && drop_ok) begin
            sem_q <= '0;
         end
      end
   end

   assign cfg_o = cfg_q;
   assign sem_o = sem_q;

endmodule

// File: rtl/pfw_access_judge.sv
`timescale 1ns/1ps
// Access verdict: attribute filter, then static or semaphore compartment filter.
module pfw_access_judge
   import pfw_pkg::*;
#(
   parameter int NUM_PERIPH = 128
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [PFW_IDX_W-1:0]      req_idx,
   input  logic [PFW_CID_W-1:0]      req_cid,
   input  logic                      req_sec,
   input  logic                      req_priv,
   input  logic [PFW_MAX_PERIPH-1:0] sec_map,
   input  logic [PFW_MAX_PERIPH-1:0] priv_map,
   input  pfw_cid_cfg_t              cfg_tab [PFW_MAX_PERIPH],
   input  pfw_sem_t                  sem_tab [PFW_MAX_PERIPH],
   output logic                      allow_o
);

   localparam logic [PFW_IDX_W:0] COUNT = (PFW_IDX_W+1)'(NUM_PERIPH);

   pfw_cid_cfg_t cfg;
   pfw_sem_t     sem;
   logic         in_range, attr_ok, cid_ok, verdict;

   always_comb begin
      cfg      = cfg_tab[req_idx];
      sem      = sem_tab[req_idx];
      in_range = {1'b0, req_idx} < COUNT;
      attr_ok  = !(sec_map[req_idx] && !req_sec) && !(priv_map[req_idx] && !req_priv);
      if (!cfg.filt_en)
         cid_ok = 1'b1;
      else if (cfg.sem_mode)
         cid_ok = cfg.allow_list[req_cid] && sem.held && (sem.owner == req_cid);
      else
         cid_ok = (req_cid == cfg.static_cid);
      verdict  = in_range && attr_ok && cid_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) allow_o <= 1'b0;
      else        allow_o <= verdict;
   end

endmodule

// File: rtl/periph_firewall.sv
`timescale 1ns/1ps
module periph_firewall
   import pfw_pkg::*;
#(
   parameter int NUM_PERIPH = 128,
   parameter int ADDR_W     = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [31:0]          cfg_wdata,
   input  logic [2:0]           cfg_wcid,
   output logic [31:0]          cfg_rdata,
   input  logic [6:0]           chk_idx,
   input  logic [2:0]           chk_cid,
   input  logic                 chk_sec,
   input  logic                 chk_priv,
   output logic                 chk_allow
);

   localparam int SID_W    = ADDR_W - 3;
   localparam int MAP_SPAN = PFW_OFF_SLOT + PFW_SLOT_STRIDE * NUM_PERIPH;

   // elaboration-time parameter checks
   if (NUM_PERIPH < 1 || NUM_PERIPH > PFW_MAX_PERIPH) begin : g_bad_count
      $error("periph_firewall: NUM_PERIPH must be within 1..128");
   end
   if (ADDR_W < 10 || ADDR_W > 16 || (1 << ADDR_W) < MAP_SPAN) begin : g_bad_addr
      $error("periph_firewall: ADDR_W too small for the register map");
   end

   logic                      glock_q;
   logic [NUM_PERIPH-1:0]     sec_bits, priv_bits, lock_bits;
   logic [PFW_MAX_PERIPH-1:0] sec_pad, priv_pad, lock_pad, held_pad;
   logic [3*PFW_MAX_PERIPH-1:0] owner_pad;
   pfw_cid_cfg_t              cfg_pad [PFW_MAX_PERIPH];
   pfw_sem_t                  sem_pad [PFW_MAX_PERIPH];
   pfw_cid_cfg_t              wr_cfg;

   assign wr_cfg = pfw_decode_cfg(cfg_wdata);

   // global lock, set once, cleared by reset only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         glock_q <= 1'b0;
      else if (cfg_wr && cfg_addr == ADDR_W'(PFW_OFF_CTRL) && cfg_wdata[0])
         glock_q <= 1'b1;
   end

   pfw_bitmap_bank #(
      .NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W), .BASE(PFW_OFF_LOCK), .SET_ONLY(1'b1)
   ) u_lock_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .hold_mask('0), .freeze(glock_q), .bits_o(lock_bits)
   );

   pfw_bitmap_bank #(
      .NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W), .BASE(PFW_OFF_SEC), .SET_ONLY(1'b0)
   ) u_sec_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .hold_mask(lock_bits), .freeze(glock_q), .bits_o(sec_bits)
   );

   pfw_bitmap_bank #(
      .NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W), .BASE(PFW_OFF_PRIV), .SET_ONLY(1'b0)
   ) u_priv_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .hold_mask(lock_bits), .freeze(glock_q), .bits_o(priv_bits)
   );

   // populated slots and zero padding up to the architectural maximum
   for (genvar gs = 0; gs < PFW_MAX_PERIPH; gs++) begin : g_slot
      if (gs < NUM_PERIPH) begin : g_live
         pfw_slot #(.ADDR_W(ADDR_W), .SLOT(gs)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
            .wr_cfg(wr_cfg), .wr_take(cfg_wdata[0]), .wr_cid(cfg_wcid),
            .locked(lock_bits[gs]), .freeze(glock_q),
            .cfg_o(cfg_pad[gs]), .sem_o(sem_pad[gs])
         );
         assign sec_pad[gs]  = sec_bits[gs];
         assign priv_pad[gs] = priv_bits[gs];
         assign lock_pad[gs] = lock_bits[gs];
      end else begin : g_vacant
         assign cfg_pad[gs]  = '0;
         assign sem_pad[gs]  = '0;
         assign sec_pad[gs]  = 1'b0;
         assign priv_pad[gs] = 1'b0;
         assign lock_pad[gs] = 1'b0;
      end
      assign held_pad[gs]          = sem_pad[gs].held;
      assign owner_pad[3*gs +: 3]  = sem_pad[gs].owner;
   end

   pfw_access_judge #(.NUM_PERIPH(NUM_PERIPH)) u_judge (
      .clk(clk), .rst_n(rst_n),
      .req_idx(chk_idx), .req_cid(chk_cid), .req_sec(chk_sec), .req_priv(chk_priv),
      .sec_map(sec_pad), .priv_map(priv_pad),
      .cfg_tab(cfg_pad), .sem_tab(sem_pad),
      .allow_o(chk_allow)
   );

   // read path
   logic [ADDR_W-1:0] slot_off;
   logic [SID_W-1:0]  slot_id;
   logic              slot_zone;

   assign slot_off  = cfg_addr - ADDR_W'(PFW_OFF_SLOT);
   assign slot_id   = slot_off[ADDR_W-1:3];
   assign slot_zone = (cfg_addr >= ADDR_W'(PFW_OFF_SLOT)) && (slot_off[1:0] == 2'b00)
                      && (int'(slot_id) < NUM_PERIPH);

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == ADDR_W'(PFW_OFF_CTRL))
         cfg_rdata[0] = glock_q;
      for (int k = 0; k < PFW_NUM_WORDS; k++) begin
         if (cfg_addr == ADDR_W'(PFW_OFF_SEC + 4 * k))  cfg_rdata = sec_pad[32*k +: 32];
         if (cfg_addr == ADDR_W'(PFW_OFF_PRIV + 4 * k)) cfg_rdata = priv_pad[32*k +: 32];
         if (cfg_addr == ADDR_W'(PFW_OFF_LOCK + 4 * k)) cfg_rdata = lock_pad[32*k +: 32];
      end
      if (slot_zone) begin
         if (slot_off[2])
            cfg_rdata = pfw_encode_sem(sem_pad[slot_id[PFW_IDX_W-1:0]]);
         else
            cfg_rdata = pfw_encode_cfg(cfg_pad[slot_id[PFW_IDX_W-1:0]]);
      end
   end

endmodule

// File: rtl/pfw_checker.sv
`timescale 1ns/1ps
module pfw_checker
   import pfw_pkg::*;
#(
   parameter int NUM_PERIPH = 128
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_wr,
   input logic [2:0]                  cfg_wcid,
   input logic                        glock,
   input logic [PFW_MAX_PERIPH-1:0]   sec_map,
   input logic [PFW_MAX_PERIPH-1:0]   priv_map,
   input logic [PFW_MAX_PERIPH-1:0]   lock_map,
   input logic [PFW_MAX_PERIPH-1:0]   held_map,
   input logic [3*PFW_MAX_PERIPH-1:0] owner_map,
   input logic [6:0]                  chk_idx,
   input logic                        chk_sec,
   input logic                        chk_priv,
   input logic                        chk_allow
);

   logic in_range;
   assign in_range = {1'b0, chk_idx} < 8'(NUM_PERIPH);

   assert_glock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      glock |=> glock);

   assert_glock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      glock |=> ($stable(sec_map) && $stable(priv_map) && $stable(lock_map)));

   assert_lock_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((lock_map & $past(lock_map)) == $past(lock_map)));

   assert_locked_attr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((sec_map ^ $past(sec_map)) | (priv_map ^ $past(priv_map))) & $past(lock_map)) == '0);

   assert_out_of_range_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_range |=> !chk_allow);

   assert_secure_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_range && sec_map[chk_idx] && !chk_sec) |=> !chk_allow);

   assert_priv_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_range && priv_map[chk_idx] && !chk_priv) |=> !chk_allow);

   for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_sem
      assert_take_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(held_map[gi]) |-> $past(cfg_wr));

      assert_release_by_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(held_map[gi]) |->
            ($past(cfg_wr) && ($past(cfg_wcid) == $past(owner_map[3*gi +: 3]))));
   end

endmodule

bind periph_firewall pfw_checker #(.NUM_PERIPH(NUM_PERIPH)) u_pfw_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wcid(cfg_wcid),
   .glock(glock_q), .sec_map(sec_pad), .priv_map(priv_pad), .lock_map(lock_pad),
   .held_map(held_pad), .owner_map(owner_pad),
   .chk_idx(chk_idx), .chk_sec(chk_sec), .chk_priv(chk_priv), .chk_allow(chk_allow)
);

// File: tb/test_periph_firewall.sv
`timescale 1ns/1ps
module test_periph_firewall;

   localparam int NP = 40;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [2:0]    cfg_wcid = '0;
   logic [31:0]   cfg_rdata;
   logic [6:0]    chk_idx = '0;
   logic [2:0]    chk_cid = '0;
   logic          chk_sec = 1'b0;
   logic          chk_priv = 1'b0;
   logic          chk_allow;

   always #2.5 clk = ~clk;

   periph_firewall #(.NUM_PERIPH(NP), .ADDR_W(AW)) i_periph_firewall (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_wcid(cfg_wcid), .cfg_rdata(cfg_rdata),
      .chk_idx(chk_idx), .chk_cid(chk_cid), .chk_sec(chk_sec), .chk_priv(chk_priv),
      .chk_allow(chk_allow)
   );

   // requirement model
   bit       m_sec [128];
   bit       m_priv[128];
   bit       m_lock[128];
   bit       m_fen [128];
   bit       m_sen [128];
   bit [2:0] m_scid[128];
   bit [7:0] m_wl  [128];
   bit       m_held[128];
   bit [2:0] m_own [128];
   bit       m_glock;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   function automatic logic [31:0] exp_rd(int a);
      logic [31:0] r;
      r = '0;
      if (a == 0) r[0] = m_glock;
      for (int k = 0; k < 4; k++) begin
         for (int j = 0; j < 32; j++) begin
            if (32*k + j < NP) begin
               if (a == 'h10 + 4*k) r[j] = m_sec [32*k + j];
               if (a == 'h30 + 4*k) r[j] = m_priv[32*k + j];
               if (a == 'h50 + 4*k) r[j] = m_lock[32*k + j];
            end
         end
      end
      if (a >= 'h100 && ((a - 'h100) % 4) == 0) begin
         int id;
         id = (a - 'h100) / 8;
         if (id < NP) begin
            if (((a - 'h100) % 8) == 0)
               r = {8'b0, m_wl[id], 9'b0, m_scid[id], 2'b0, m_sen[id], m_fen[id]};
            else
               r = {25'b0, m_own[id], 3'b0, m_held[id]};
         end
      end
      return r;
   endfunction

   function automatic bit exp_allow(int idx, int cid, bit s, bit p);
      if (idx >= NP) return 0;
      if (m_sec[idx] && !s) return 0;
      if (m_priv[idx] && !p) return 0;
      if (!m_fen[idx]) return 1;
      if (m_sen[idx]) return m_wl[idx][cid] && m_held[idx] && (m_own[idx] == 3'(cid));
      return m_scid[idx] == 3'(cid);
   endfunction

   task automatic wr(input int a, input logic [31:0] d, input logic [2:0] c);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d; cfg_wcid = c;
      // model update from the requirements
      if (a == 0 && d[0]) m_glock = 1;
      for (int k = 0; k < 4; k++) begin
         for (int j = 0; j < 32; j++) begin
            int id;
            id = 32*k + j;
            if (id < NP && !m_glock) begin
               if (a == 'h10 + 4*k && !m_lock[id]) m_sec[id]  = d[j];
               if (a == 'h30 + 4*k && !m_lock[id]) m_priv[id] = d[j];
               if (a == 'h50 + 4*k && d[j])        m_lock[id] = 1;
            end
         end
      end
      if (a >= 'h100 && ((a - 'h100) % 4) == 0) begin
         int id;
         id = (a - 'h100) / 8;
         if (id < NP) begin
            if (((a - 'h100) % 8) == 0) begin
               if (!m_lock[id] && !m_glock) begin
                  m_fen[id] = d[0]; m_sen[id] = d[1]; m_scid[id] = d[6:4]; m_wl[id] = d[23:16];
               end
            end else if (d[0]) begin
               if (!m_held[id] && m_sen[id] && m_wl[id][c]) begin
                  m_held[id] = 1; m_own[id] = c;
               end
            end else if (m_held[id] && m_own[id] == c) begin
               m_held[id] = 0; m_own[id] = 0;
            end
         end
      end
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_check(input int a, input string req);
      @(negedge clk);
      cfg_addr = AW'(a);
      #1;
      checks++;
      if (cfg_rdata !== exp_rd(a)) begin
         fails++;
         $display("FAIL %s read addr 0x%03h actual 0x%08h expected 0x%08h",
                  req, a, cfg_rdata, exp_rd(a));
      end
   endtask

   task automatic acc_check(input int idx, input int cid, input bit s, input bit p,
                            input string req);
      @(negedge clk);
      chk_idx = 7'(idx); chk_cid = 3'(cid); chk_sec = s; chk_priv = p;
      @(posedge clk);
      #1;
      checks++;
      if (chk_allow !== exp_allow(idx, cid, s, p)) begin
         fails++;
         $display("FAIL %s access idx=%0d cid=%0d sec=%0b priv=%0b actual %0b expected %0b",
                  req, idx, cid, s, p, chk_allow, exp_allow(idx, cid, s, p));
      end
   endtask

   // R11 latency is exercised by every access check: sampled right after the next edge
   task automatic acc_sweep(input string req);
      for (int idx = 0; idx < NP + 4; idx++)
         for (int cid = 0; cid < 8; cid++)
            for (int sp = 0; sp < 4; sp++)
               acc_check(idx, cid, sp[0], sp[1], req);
   endtask

   task automatic rd_sweep(input string req);
      rd_check('h0, req);
      for (int k = 0; k < 4; k++) begin
         rd_check('h10 + 4*k, req);
         rd_check('h30 + 4*k, req);
         rd_check('h50 + 4*k, req);
      end
      for (int id = 0; id < NP + 2; id++) begin
         rd_check('h100 + 8*id, req);
         rd_check('h104 + 8*id, req);
      end
   endtask

   // watchdog
   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state and open access
      rd_sweep("R1");
      acc_sweep("R1 R10 R11");

      // R2 attribute bitmaps, including the partly populated second word
      wr('h10, 32'hA5A5_A5A5, 3'd0);
      wr('h14, 32'hFFFF_FFC3, 3'd0);
      wr('h18, 32'hFFFF_FFFF, 3'd0);   // R10 vacant word ignored
      wr('h30, 32'h0F0F_1234, 3'd0);
      wr('h34, 32'h0000_003C, 3'd0);
      wr('h3C, 32'hFFFF_FFFF, 3'd0);   // R10 vacant word ignored
      rd_sweep("R2 R10");

      // R4 compartment words with a mix of modes
      for (int i = 0; i < NP; i++) begin
         logic [31:0] d;
         d = '0;
         d[0]     = (i % 3) != 0;
         d[1]     = (i % 3) == 2;
         d[6:4]   = 3'(i);
         d[23:16] = 8'((i * 37) ^ 8'h5A);
         d[31:24] = 8'hFF;               // not a field: must read back 0
         d[15:7]  = 9'h1FF;
         wr('h100 + 8*i, d, 3'd0);
      end
      wr('h100 + 8*(NP + 1), 32'h00FF_0073, 3'd0);  // R10 beyond last slot
      rd_sweep("R4 R10");

      // R6 / R7 directed semaphore cases on peripheral 2
      wr('h100 + 8*2, 32'h000A_0003, 3'd0);  // allow list: compartments 1 and 3
      wr('h104 + 8*2, 32'h1, 3'd0);          // not listed
      rd_check('h104 + 8*2, "R6 take by unlisted compartment");
      wr('h104 + 8*2, 32'h1, 3'd3);
      rd_check('h104 + 8*2, "R6 take by listed compartment");
      wr('h104 + 8*2, 32'h1, 3'd1);
      rd_check('h104 + 8*2, "R6 take while held");
      wr('h104 + 8*2, 32'h0, 3'd1);
      rd_check('h104 + 8*2, "R7 release by non-owner");
      acc_check(2, 3, 1, 1, "R5 holder allowed");
      acc_check(2, 1, 1, 1, "R5 listed non-holder denied");
      wr('h104 + 8*2, 32'h0, 3'd3);
      rd_check('h104 + 8*2, "R7 release by owner");
      acc_check(2, 3, 1, 1, "R5 released denied");
      wr('h104 + 8*3, 32'h1, 3'd0);          // semaphore mode off on id 3
      rd_check('h104 + 8*3, "R6 take without semaphore mode");
      wr('h104 + 8*(NP + 1), 32'h1, 3'd0);
      rd_check('h104 + 8*(NP + 1), "R10 semaphore beyond last slot");

      // populate semaphores across all slots with several compartments
      for (int i = 0; i < NP; i++) begin
         wr('h104 + 8*i, 32'h1, 3'(i));
         wr('h104 + 8*i, 32'h1, 3'(i + 5));
         if (i % 4 == 1) wr('h104 + 8*i, 32'h0, 3'(i + 2));
      end
      rd_sweep("R6 R7");
      acc_sweep("R3 R4 R5");

      // R8 per-peripheral locks
      wr('h50, 32'h0000_0035, 3'd0);         // ids 0, 2, 4, 5
      wr('h54, 32'h0000_0102, 3'd0);         // id 33 (bit 8 is vacant)
      wr('h50, 32'h0000_0000, 3'd0);         // no clear
      wr('h10, 32'h0000_0000, 3'd0);
      wr('h30, 32'hFFFF_FFFF, 3'd0);
      wr('h14, 32'h0000_0000, 3'd0);
      wr('h100 + 8*0, 32'h0001_0021, 3'd0);
      wr('h100 + 8*33, 32'h0000_0000, 3'd0);
      wr('h100 + 8*6, 32'h0000_0071, 3'd0);  // unlocked: takes effect
      wr('h104 + 8*5, 32'h0, 3'd5);          // semaphores unaffected by locks
      rd_sweep("R8");
      acc_sweep("R8 R3 R4");

      // R9 global lock
      wr('h0, 32'h1, 3'd0);
      rd_check('h0, "R9 global lock reads 1");
      wr('h0, 32'h0, 3'd0);
      rd_check('h0, "R9 global lock not clearable");
      wr('h10, 32'hFFFF_FFFF, 3'd0);
      wr('h30, 32'h0000_0000, 3'd0);
      wr('h54, 32'h0000_00FF, 3'd0);
      wr('h100 + 8*7, 32'h0000_0000, 3'd0);
      wr('h100 + 8*8, 32'h00FF_0003, 3'd0);
      for (int i = 0; i < NP; i++) begin
         wr('h104 + 8*i, 32'h0, 3'(i + 5));
         wr('h104 + 8*i, 32'h1, 3'(i + 6));
      end
      rd_sweep("R9");
      acc_sweep("R9 R5 R10");

      done = 1;
      report();
      $finish;
   end

endmodule